// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry Flag

This block moves a data word left or right by a count, using one of eight operations: logical, arithmetic, plain rotate, and rotate through the carry flag, each in both directions. The caller supplies the word, a 3-bit operation code, a shift count and the present carry flag. The block returns the shifted word, the updated carry flag, and zero and negative flags for that word.

The carry flag has two jobs. For shifts and plain rotates it holds the last bit that left the word. For the through-carry rotates it is one more place in the ring, so the ring is one bit wider than the word. A pulse on `go` takes the inputs. One clock edge later the results appear on the registered outputs, and they stay there until the next pulse.

Top module: `shr_unit`

## Requirements
- R1: Operation codes: 0 = logical left, 2 = arithmetic left, 1 = logical right, 3 = arithmetic right, 4 = rotate left, 5 = rotate right, 6 = rotate left through carry, 7 = rotate right through carry. For codes 0 and 2 with count k (1..WIDTH), the result is din shifted left by k with zeros filling from the bottom, and the carry is din[WIDTH-k]. For k > WIDTH, the result and carry are both 0.
- R2: For code 1 with count k (1..WIDTH), the result is din shifted right with zeros filling from the top, and the carry is din[k-1]. For k > WIDTH, the result and carry are both 0.
- R3: For code 3, the vacated top bits take the original din[WIDTH-1], and the carry is din[k-1]. For k >= WIDTH, every result bit and the carry equal the original sign bit.
- R4: Codes 4 and 5 rotate the word by k modulo WIDTH. For a nonzero count, the carry is the last bit that wrapped: result bit 0 for code 4, and result bit WIDTH-1 for code 5.
- R5: Codes 6 and 7 rotate the ring {carry, din} of WIDTH+1 bits by k modulo WIDTH+1. The new carry is the top bit of the ring and the result is the lower WIDTH bits.
- R6: A count of 0 returns din unchanged and passes cin to the carry output, for every code.
- R7: zero is 1 exactly when the result is all zeros. neg equals the top bit of the result.
- R8: Outputs change only on the clock edge where go is 1 and hold otherwise. Reset drives dout, cout, zero and neg to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Capture inputs and update outputs on this edge |
| op | input | 3 | Operation code (see R1) |
| amount | input | CNT_W | Shift or rotate count |
| din | input | WIDTH | Data word |
| cin | input | 1 | Present carry flag |
| dout | output | WIDTH | Shifted word |
| cout | output | 1 | New carry flag |
| zero | output | 1 | Result is all zeros |
| neg | output | 1 | Top bit of the result |

## Verification
The hardest cases to reach are counts past the word width. These include a through-carry rotate by exactly WIDTH+1, which must restore both the word and the carry, and a plain rotate by exactly WIDTH, which leaves the word intact but must still update the carry. The stimulus sweeps every operation over the counts 0, 1, 2, WIDTH-1, WIDTH, WIDTH+1 and the largest count, with each carry value, and then runs random words. The reference model shifts one bit at a time, so its count wraps on its own and does not use a modulo.

// File: rtl/shr_pkg.sv
package shr_pkg;
  typedef enum logic [2:0] {
    OP_LSL  = 3'd0,
    OP_LSR  = 3'd1,
    OP_ASL  = 3'd2,
    OP_ASR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_RCL  = 3'd6,
    OP_RCR  = 3'd7
  } shift_op_e;
endpackage

// File: rtl/shr_linear.sv
// Logical and arithmetic shifts; the carry falls out of the widened shift.
module shr_linear #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input  logic [WIDTH-1:0] din,
  input  logic [CNT_W-1:0] amt,
  output logic [WIDTH-1:0] left_res,
  output logic             left_cy,
  output logic [WIDTH-1:0] right_res,
  output logic             right_cy,
  output logic [WIDTH-1:0] arith_res,
  output logic             arith_cy
);
  localparam int DW = 2 * WIDTH;

  logic [WIDTH-2:0]    left_hi_unused;
  logic [WIDTH-2:0]    right_lo_unused;
  logic [WIDTH-2:0]    arith_lo_unused;
  logic signed [DW-1:0] arith_wide;

  // bit WIDTH of the widened vector is the last bit pushed out of the word
  assign {left_hi_unused, left_cy, left_res} = {{WIDTH{1'b0}}, din} << amt;
  assign {right_res, right_cy, right_lo_unused} = {din, {WIDTH{1'b0}}} >> amt;

  assign arith_wide = $signed({din, {WIDTH{1'b0}}}) >>> amt;
  assign {arith_res, arith_cy, arith_lo_unused} = arith_wide;
endmodule

// File: rtl/shr_ring.sv
// Rotates a ring of RW bits both ways by amt modulo RW.
module shr_ring #(
  parameter int RW    = 32,
  parameter int CNT_W = 6
) (
  input  logic [RW-1:0]    ring,
  input  logic [CNT_W-1:0] amt,
  output logic [RW-1:0]    rot_l,
  output logic [RW-1:0]    rot_r
);
  localparam bit POW2 = (RW & (RW - 1)) == 0;

  int unsigned          k;
  logic [2*RW-1:0]      dbl_l;
  logic [2*RW-1:0]      dbl_r;
  logic [RW-1:0]        dbl_l_unused;
  logic [RW-1:0]        dbl_r_unused;

  generate
    if (POW2) begin : g_mask
      always_comb k = 32'(amt) & 32'(RW - 1);
    end else begin : g_mod
      always_comb k = 32'(amt) % 32'(RW);
    end
  endgenerate

  assign dbl_l = {ring, ring} << k;
  assign dbl_r = {ring, ring} >> k;
  assign {rot_l, dbl_l_unused} = dbl_l;
  assign {dbl_r_unused, rot_r} = dbl_r;
endmodule

// File: rtl/shr_flags.sv
module shr_flags #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] res,
  output logic             is_zero,
  output logic             is_neg
);
  assign is_zero = ~|res;
  assign is_neg  = res[WIDTH-1];
endmodule

// File: rtl/shr_unit.sv
module shr_unit #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [2:0]       op,
  input  logic [CNT_W-1:0] amount,
  input  logic [WIDTH-1:0] din,
  input  logic             cin,
  output logic [WIDTH-1:0] dout,
  output logic             cout,
  output logic             zero,
  output logic             neg
);
  import shr_pkg::*;

  localparam int RW_C = WIDTH + 1;

  shift_op_e        op_e;
  logic [WIDTH-1:0] l_res, r_res, a_res;
  logic             l_cy, r_cy, a_cy;
  logic [WIDTH-1:0] p_l, p_r;
  logic [RW_C-1:0]  c_l, c_r;
  logic [WIDTH-1:0] res_nxt;
  logic             cy_sel, cy_nxt, z_nxt, n_nxt;
  logic [WIDTH-1:0] res_q;
  logic             cy_q, z_q, n_q;

  assign op_e = shift_op_e'(op);

  shr_linear #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_lin (
    .din(din), .amt(amount),
    .left_res(l_res), .left_cy(l_cy),
    .right_res(r_res), .right_cy(r_cy),
    .arith_res(a_res), .arith_cy(a_cy)
  );

  shr_ring #(.RW(WIDTH), .CNT_W(CNT_W)) u_plain (
    .ring(din), .amt(amount), .rot_l(p_l), .rot_r(p_r)
  );

  shr_ring #(.RW(RW_C), .CNT_W(CNT_W)) u_thru (
    .ring({cin, din}), .amt(amount), .rot_l(c_l), .rot_r(c_r)
  );

  always_comb begin
    unique case (op_e)
      OP_LSL, OP_ASL: begin res_nxt = l_res;            cy_sel = l_cy;          end
      OP_LSR:         begin res_nxt = r_res;            cy_sel = r_cy;          end
      OP_ASR:         begin res_nxt = a_res;            cy_sel = a_cy;          end
      OP_ROL:         begin res_nxt = p_l;              cy_sel = p_l[0];        end
      OP_ROR:         begin res_nxt = p_r;              cy_sel = p_r[WIDTH-1];  end
      OP_RCL:         begin res_nxt = c_l[WIDTH-1:0];   cy_sel = c_l[WIDTH];    end
      OP_RCR:         begin res_nxt = c_r[WIDTH-1:0];   cy_sel = c_r[WIDTH];    end
      default:        begin res_nxt = din;              cy_sel = cin;           end
    endcase
    cy_nxt = (amount == '0) ? cin : cy_sel;
  end

  shr_flags #(.WIDTH(WIDTH)) u_flg (
    .res(res_nxt), .is_zero(z_nxt), .is_neg(n_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      cy_q  <= 1'b0;
      z_q   <= 1'b0;
      n_q   <= 1'b0;
    end else if (go) begin
      res_q <= res_nxt;
      cy_q  <= cy_nxt;
      z_q   <= z_nxt;
      n_q   <= n_nxt;
    end
  end

  assign dout = res_q;
  assign cout = cy_q;
  assign zero = z_q;
  assign neg  = n_q;
endmodule

// File: rtl/shr_unit_chk.sv
module shr_unit_chk #(
  parameter int WIDTH = 32,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go,
  input logic [2:0]       op,
  input logic [CNT_W-1:0] amount,
  input logic [WIDTH-1:0] din,
  input logic             cin,
  input logic [WIDTH-1:0] dout,
  input logic             cout,
  input logic             zero,
  input logic             neg
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> ($stable(dout) && $stable(cout) && $stable(zero) && $stable(neg)));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (zero == (dout == '0)));

  assert_neg_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (neg == dout[WIDTH-1]));

  assert_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && amount == '0) |=> (dout == $past(din) && cout == $past(cin)));

  assert_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 3'd3) |=> (dout[WIDTH-1] == $past(din[WIDTH-1])));

  assert_rol_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 3'd4 && amount != '0) |=> (cout == dout[0]));

  assert_ror_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == 3'd5 && amount != '0) |=> (cout == dout[WIDTH-1]));
endmodule

bind shr_unit shr_unit_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_shr_unit.sv
`timescale 1ns/1ps
module sim_shr_unit;
  localparam int W  = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          go;
  logic [2:0]    op;
  logic [CW-1:0] amount;
  logic [W-1:0]  din;
  logic          cin;
  logic [W-1:0]  dout;
  logic          cout, zero, neg;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [W-1:0] exp_d = '0;
  logic         exp_c = 1'b0;

  always #2.5 clk = ~clk;

  shr_unit #(.WIDTH(W), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .op(op), .amount(amount),
    .din(din), .cin(cin), .dout(dout), .cout(cout), .zero(zero), .neg(neg)
  );

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd2: return "R1";
      3'd1:       return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5: return "R4";
      default:    return "R5";
    endcase
  endfunction

  // one bit per step; the count wraps by itself
  task automatic model(input logic [2:0] o, input int k,
                       input logic [W-1:0] d, input logic c);
    logic [W-1:0] v = d;
    logic         cy = c;
    logic         t;
    for (int s = 0; s < k; s++) begin
      case (o)
        3'd0, 3'd2: begin cy = v[W-1]; v = {v[W-2:0], 1'b0}; end
        3'd1:       begin cy = v[0];   v = {1'b0, v[W-1:1]}; end
        3'd3:       begin cy = v[0];   v = {v[W-1], v[W-1:1]}; end
        3'd4:       begin cy = v[W-1]; v = {v[W-2:0], v[W-1]}; end
        3'd5:       begin cy = v[0];   v = {v[0], v[W-1:1]}; end
        3'd6:       begin t = v[W-1];  v = {v[W-2:0], cy}; cy = t; end
        default:    begin t = v[0];    v = {cy, v[W-1:1]}; cy = t; end
      endcase
    end
    exp_d = v;
    exp_c = cy;
  endtask

  task automatic chk(input string req, input string what, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "dout", dout, exp_d);
    chk(req, "cout", W'(cout), W'(exp_c));
    chk("R7", "zero", W'(zero), W'(exp_d == '0));
    chk("R7", "neg", W'(neg), W'(exp_d[W-1]));
  endtask

  task automatic issue(input logic [2:0] o, input int k, input logic [W-1:0] d,
                       input logic c);
    go = 1'b1; op = o; amount = CW'(k); din = d; cin = c;
    model(o, k, d, c);
    @(negedge clk);
    go = 1'b0;
    compare(k == 0 ? "R6" : req_of(o));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      op = 3'($urandom); amount = CW'($urandom); din = $urandom; cin = 1'($urandom);
      @(negedge clk);
      compare("R8");
    end
  endtask

  initial begin
    int cnts[7] = '{0, 1, 2, W - 1, W, W + 1, (1 << CW) - 1};
    logic [W-1:0] pats[3] = '{32'h8000_0001, 32'h7654_3210, 32'hFFFF_FFFF};
    rst_n = 1'b0; go = 1'b0; op = '0; amount = '0; din = '0; cin = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8", "reset dout", dout, '0);
    chk("R8", "reset flags", W'({cout, zero, neg}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int o = 0; o < 8; o++)
      foreach (cnts[i])
        foreach (pats[j])
          for (int c = 0; c < 2; c++)
            issue(3'(o), cnts[i], pats[j], 1'(c));
    issue(3'd0, 4, '0, 1'b1);          // R7: zero result
    idle(4);
    for (int n = 0; n < 400; n++) begin
      issue(3'($urandom), int'($urandom_range(0, (1 << CW) - 1)), $urandom, 1'($urandom));
      if (n % 16 == 0) idle(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule